// File: doc/BRIEF.md
# Cascaded Interrupt Controller Core

This block collects a set of main interrupt request lines and a smaller set of secondary request lines into one interrupt output for a processor. The secondary lines are latched in their own pending register and gated by their own mask. Each group of three secondary bits then drives one chosen main line as a level request. Every main line, whether it comes from a pin or from a secondary group, sets a sticky pending bit. Software clears that bit by writing a 1 to it.

Among the pending main bits whose mask bit is 0, the lowest-numbered one is moved into a one-hot service register, and only when that register is empty. The interrupt output is high while the service register holds a bit. A read-only index register gives the number of that bit, so the handler never has to scan. The handler clears the main pending bit, then the service bit, and the next candidate is picked.

All state sits behind a small 32-bit register port with single-cycle read and write strobes. Read data is registered: it appears one cycle after the read strobe and is held until the next read.

Top module: `icc_core`

## Requirements
- R1: After reset the main mask reads 0xFFFFFFFF, the secondary mask reads 0x7FF, the main pending, secondary pending and service registers read 0, the index reads 0 and `irq` is low.
- R2: A main request that is high at a clock edge sets its main pending bit, and the bit stays set until a write of 1 to that bit at offset 0x00. Bits written as 0 keep their value.
- R3: When a request and a write-1 clear hit the same pending bit (main or secondary) in the same cycle, the bit stays set.
- R4: When the service register (offset 0x08) is zero and some main pending bit has its mask bit (offset 0x04, 1 = masked) at 0, the lowest-numbered such bit is loaded into the service register at the next clock. Masked bits are never chosen.
- R5: The service register has at most one bit set. While it is non-zero it changes only through a write-1 clear, even when new, lower-numbered requests arrive.
- R6: The index register (offset 0x0C) reads the bit number of the set service bit, and 0 when the service register is empty.
- R7: `irq` is high exactly while the service register is non-zero.
- R8: The service register clears on write-1. Once it is empty, it can be reloaded at the clock after it is first seen empty.
- R9: Each of the 11 secondary requests sets its own bit in the secondary pending register (offset 0x10). That register clears on write-1.
- R10: The secondary mask (offset 0x14, 11 bits, 1 = masked) gates the groups. Secondary bits 0-2 drive main line 28, bits 3-5 drive line 23, bits 6-8 drive line 15, and bits 9-10 drive line 31. A main line is requested on every cycle in which some bit of its group is pending and unmasked.
- R11: Read data appears on `reg_rdata` at the clock after `reg_rd` and holds until the next read. A register is selected only by a word-aligned offset. Unmapped offsets read 0. Writes to the index register and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_req | input | 32 | Synchronised main request lines, level or pulse |
| sub_req | input | 11 | Synchronised secondary request lines |
| reg_addr | input | 5 | Byte offset of the register access |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Four properties are checked on every cycle. The service register stays one-hot or empty. A load from an empty service register takes the lowest unmasked pending bit. A set service bit holds unless it is cleared. A request always beats a clear on the same edge. Other things only the bench's scenarios can show: the secondary-to-main mapping of each group, the exact value read from each offset, the effect of writes to the index register and to unmapped offsets, and the ordering of clear and reload in a handler sequence. The bench covers these by comparing a behavioural model with the outputs on every clock.

// File: rtl/icc_pkg.sv
// Shared constants for the cascaded interrupt controller.
// Assumes word-aligned byte offsets on a 32-bit register port.
package icc_pkg;

    // Word index of each register (byte offset / 4).
    localparam int REG_MAIN_PEND = 0;
    localparam int REG_MAIN_MASK = 1;
    localparam int REG_SERVICE   = 2;
    localparam int REG_INDEX     = 3;
    localparam int REG_SUB_PEND  = 4;
    localparam int REG_SUB_MASK  = 5;

    // Width of one field in the parent map parameter.
    localparam int MAP_FIELD_W = 8;

endpackage

// File: rtl/icc_pend_bank.sv
// Sticky pending register bank with write-1-to-clear.
// A set request wins over a clear on the same bit and edge.
// Assumes set and clr are synchronous to clk.
module icc_pend_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    // Keep bits until cleared; new requests override clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_i) | set_i;
        end
    end

    // R2 / R3: every requested bit is set after the edge, whatever was cleared.
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/icc_cascade.sv
// Reduces the secondary pending bits to parent main-line requests.
// Each group of GRP consecutive secondary bits drives one main line,
// picked by an 8-bit field of PARENT_MAP (group 0 in the lowest field).
// Assumes at most 8 groups.
module icc_cascade #(
    parameter int          NUM_SUB    = 11,
    parameter int          GRP        = 3,
    parameter int          NUM_MAIN   = 32,
    parameter logic [63:0] PARENT_MAP = 64'h0000_0000_1F0F_171C
) (
    input  logic [NUM_SUB-1:0]  sub_pend_i,
    input  logic [NUM_SUB-1:0]  sub_mask_i,
    output logic [NUM_MAIN-1:0] parent_req_o
);
    import icc_pkg::*;

    localparam int NGRP = (NUM_SUB + GRP - 1) / GRP;
    localparam int IDXW = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1;

    logic [NUM_SUB-1:0] live;
    logic [NGRP-1:0]    grp_hit;

    // Pending and unmasked secondary bits.
    assign live = sub_pend_i & ~sub_mask_i;

    // One OR reduction per group; the last group may be short.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GRP;
        localparam int HI = ((LO + GRP - 1) < NUM_SUB) ? (LO + GRP - 1) : (NUM_SUB - 1);
        assign grp_hit[g] = |live[HI:LO];
    end

    // Route each group's hit onto its parent main line.
    always_comb begin
        parent_req_o = '0;
        for (int g = 0; g < NGRP; g++) begin
            parent_req_o[PARENT_MAP[g*MAP_FIELD_W +: IDXW]] =
                parent_req_o[PARENT_MAP[g*MAP_FIELD_W +: IDXW]] | grp_hit[g];
        end
    end

endmodule

// File: rtl/icc_arbiter.sv
// One-hot service register with lowest-number-first loading.
// Loads only when empty; a set bit leaves only through write-1 clear.
// Also encodes the set bit into a binary index (0 when empty).
module icc_arbiter #(
    parameter int N = 32,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    cand_i,
    input  logic [N-1:0]    clr_i,
    output logic [N-1:0]    act_o,
    output logic [IDXW-1:0] idx_o
);

    logic [N-1:0] pick;

    // Lowest-numbered candidate as a one-hot vector.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    // Hold while occupied, load the pick while empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o <= '0;
        end else if (act_o != '0) begin
            act_o <= act_o & ~clr_i;
        end else begin
            act_o <= pick;
        end
    end

    // Binary index of the service bit.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (act_o[i]) begin
                idx_o = IDXW'(i);
            end
        end
    end

    // R5: never more than one service bit.
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_o));

    // R5: an occupied register holds unless its bit is cleared.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o != '0 && (act_o & clr_i) == '0) |=> $stable(act_o));

    // R4: an empty register with candidates loads one of them.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o == '0 && cand_i != '0) |=>
            (act_o != '0 && (act_o & $past(cand_i)) == act_o));

    // R4: nothing below the loaded bit was a candidate.
    p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o == '0 && cand_i != '0) |=> (((act_o - 1'b1) & $past(cand_i)) == '0));

    // R6: the index names a set service bit.
    p_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o != '0) |-> act_o[idx_o]);

endmodule

// File: rtl/icc_core.sv
// Cascaded interrupt controller top level.
// Holds the main and secondary masks and the read port; instantiates the
// pending banks, the secondary cascade and the service arbiter.
// Assumes requests are already synchronised to clk; reset is synchronous.
module icc_core #(
    parameter int          NUM_MAIN   = 32,
    parameter int          NUM_SUB    = 11,
    parameter int          GRP        = 3,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 5,
    parameter logic [63:0] PARENT_MAP = 64'h0000_0000_1F0F_171C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MAIN-1:0] main_req,
    input  logic [NUM_SUB-1:0]  sub_req,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_rd,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);
    import icc_pkg::*;

    localparam int IDXW  = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1;
    localparam int SEL_W = ADDR_W - 2;

    logic [SEL_W-1:0]    sel;
    logic                aligned;
    logic                wr_main_pend, wr_main_mask, wr_service, wr_sub_pend, wr_sub_mask;
    logic [NUM_MAIN-1:0] main_mask_q, main_pend_q, act_q, parent_req, main_set;
    logic [NUM_MAIN-1:0] main_clr, act_clr;
    logic [NUM_SUB-1:0]  sub_mask_q, sub_pend_q, sub_clr;
    logic [IDXW-1:0]     act_idx;
    logic [DATA_W-1:0]   rd_val;

    // Register decode: word index and alignment check.
    assign sel     = reg_addr[ADDR_W-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);

    // Per-register write strobes.
    always_comb begin
        wr_main_pend = reg_wr && aligned && (int'(sel) == REG_MAIN_PEND);
        wr_main_mask = reg_wr && aligned && (int'(sel) == REG_MAIN_MASK);
        wr_service   = reg_wr && aligned && (int'(sel) == REG_SERVICE);
        wr_sub_pend  = reg_wr && aligned && (int'(sel) == REG_SUB_PEND);
        wr_sub_mask  = reg_wr && aligned && (int'(sel) == REG_SUB_MASK);
    end

    // Clear vectors for the write-1-to-clear registers.
    assign main_clr = wr_main_pend ? reg_wdata[NUM_MAIN-1:0] : '0;
    assign act_clr  = wr_service   ? reg_wdata[NUM_MAIN-1:0] : '0;
    assign sub_clr  = wr_sub_pend  ? reg_wdata[NUM_SUB-1:0]  : '0;

    // Mask registers: all sources start masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_mask_q <= '1;
            sub_mask_q  <= '1;
        end else begin
            if (wr_main_mask) main_mask_q <= reg_wdata[NUM_MAIN-1:0];
            if (wr_sub_mask)  sub_mask_q  <= reg_wdata[NUM_SUB-1:0];
        end
    end

    // Secondary pending bits.
    icc_pend_bank #(.WIDTH(NUM_SUB)) u_sub_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sub_req),
        .clr_i (sub_clr),
        .q_o   (sub_pend_q)
    );

    // Secondary groups onto their parent main lines.
    icc_cascade #(
        .NUM_SUB    (NUM_SUB),
        .GRP        (GRP),
        .NUM_MAIN   (NUM_MAIN),
        .PARENT_MAP (PARENT_MAP)
    ) u_cascade (
        .sub_pend_i   (sub_pend_q),
        .sub_mask_i   (sub_mask_q),
        .parent_req_o (parent_req)
    );

    // Main pending bits, set by pins or by the cascade.
    assign main_set = main_req | parent_req;

    icc_pend_bank #(.WIDTH(NUM_MAIN)) u_main_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (main_set),
        .clr_i (main_clr),
        .q_o   (main_pend_q)
    );

    // Service register and index encoder.
    icc_arbiter #(.N(NUM_MAIN)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (main_pend_q & ~main_mask_q),
        .clr_i  (act_clr),
        .act_o  (act_q),
        .idx_o  (act_idx)
    );

    assign irq = |act_q;

    // Read multiplexer.
    always_comb begin
        rd_val = '0;
        if (aligned) begin
            case (int'(sel))
                REG_MAIN_PEND: rd_val = DATA_W'(main_pend_q);
                REG_MAIN_MASK: rd_val = DATA_W'(main_mask_q);
                REG_SERVICE:   rd_val = DATA_W'(act_q);
                REG_INDEX:     rd_val = DATA_W'(act_idx);
                REG_SUB_PEND:  rd_val = DATA_W'(sub_pend_q);
                REG_SUB_MASK:  rd_val = DATA_W'(sub_mask_q);
                default:       rd_val = '0;
            endcase
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_val;
        end
    end

    // R11: read data moves only after a read strobe.
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R7: irq rises only after an unmasked pending bit was present.
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(main_pend_q & ~main_mask_q) != '0));

endmodule

// File: tb/icc_core_test.sv
// Bench: a behavioural model updated on every rising edge and compared on
// every falling edge, plus directed scenarios with hand-computed values.
module icc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] main_req = '0;
    logic [10:0] sub_req = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    icc_core uut (
        .clk(clk), .rst_n(rst_n), .main_req(main_req), .sub_req(sub_req),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural model state.
    logic [31:0] m_pend, m_mask, m_act, m_rdata;
    logic [10:0] m_sub, m_smask;

    function automatic int parent_of(input int g);
        case (g)
            0: return 28;
            1: return 23;
            2: return 15;
            default: return 31;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        int idx = 0;
        for (int i = 0; i < 32; i++) if (m_act[i]) idx = i;
        case (a)
            5'h00: return m_pend;
            5'h04: return m_mask;
            5'h08: return m_act;
            5'h0C: return 32'(idx);
            5'h10: return {21'd0, m_sub};
            5'h14: return {21'd0, m_smask};
            default: return 32'd0;
        endcase
    endfunction

    // Model step on each rising edge.
    always @(posedge clk) begin
        logic [31:0] n_pend, n_act, cand, clr;
        logic [10:0] n_sub;
        if (!rst_n) begin
            m_pend = 0; m_mask = '1; m_act = 0; m_sub = 0; m_smask = '1; m_rdata = 0;
        end else begin
            if (reg_rd) m_rdata = m_read(reg_addr);
            clr = (reg_wr && reg_addr == 5'h00) ? reg_wdata : 32'd0;
            n_pend = (m_pend & ~clr) | main_req;
            for (int b = 0; b < 11; b++)
                if (m_sub[b] && !m_smask[b]) n_pend[parent_of(b / 3)] = 1'b1;
            n_sub = (m_sub & ~((reg_wr && reg_addr == 5'h10) ? reg_wdata[10:0] : 11'd0)) | sub_req;
            cand = m_pend & ~m_mask;
            if (m_act != 0) begin
                n_act = m_act & ~((reg_wr && reg_addr == 5'h08) ? reg_wdata : 32'd0);
            end else begin
                n_act = 0;
                for (int i = 31; i >= 0; i--) if (cand[i]) n_act = 32'd1 << i;
            end
            if (reg_wr && reg_addr == 5'h04) m_mask = reg_wdata;
            if (reg_wr && reg_addr == 5'h14) m_smask = reg_wdata[10:0];
            m_pend = n_pend; m_sub = n_sub; m_act = n_act;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(irq === (m_act != 0), "R7 irq", {31'd0, irq}, {31'd0, m_act != 0});
            check(reg_rdata === m_rdata, "R11 rdata", reg_rdata, m_rdata);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic pulse_main(input logic [31:0] v);
        @(negedge clk); main_req = v;
        @(negedge clk); main_req = '0;
    endtask

    task automatic pulse_sub(input logic [10:0] v);
        @(negedge clk); sub_req = v;
        @(negedge clk); sub_req = '0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1: reset values
        check(irq === 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
        rd_chk(5'h04, 32'hFFFF_FFFF, "R1 main mask");
        rd_chk(5'h14, 32'h0000_07FF, "R1 sub mask");
        rd_chk(5'h00, 32'h0, "R1 main pend");
        rd_chk(5'h08, 32'h0, "R1 service");
        rd_chk(5'h0C, 32'h0, "R1 index");
        rd_chk(5'h10, 32'h0, "R1 sub pend");

        // R2: sticky pending, write-1 clear affects only written ones
        pulse_main(32'h20);
        idle(2);
        rd_chk(5'h00, 32'h20, "R2 set");
        wr(5'h00, 32'h1);
        rd_chk(5'h00, 32'h20, "R2 zero bits kept");
        wr(5'h00, 32'h20);
        rd_chk(5'h00, 32'h0, "R2 cleared");
        check(irq === 1'b0, "R4 masked no irq", {31'd0, irq}, 32'd0);

        // R3: request beats clear
        @(negedge clk); main_req = 32'h80;
        idle(2);
        wr(5'h00, 32'h80);
        main_req = '0;
        rd_chk(5'h00, 32'h80, "R3 main set wins");
        wr(5'h00, 32'h80);
        rd_chk(5'h00, 32'h0, "R3 cleanup");

        // R4 / R6 / R7: lowest unmasked wins
        pulse_main(32'h0010_0210);
        idle(2);
        wr(5'h04, 32'h0);
        idle(3);
        rd_chk(5'h08, 32'h10, "R4 lowest loaded");
        rd_chk(5'h0C, 32'd4, "R6 index 4");
        check(irq === 1'b1, "R7 irq high", {31'd0, irq}, 32'd1);
        // R5: lower request does not replace
        pulse_main(32'h4);
        idle(3);
        rd_chk(5'h08, 32'h10, "R5 held");
        // R8: clear and reload
        wr(5'h00, 32'h10);
        wr(5'h08, 32'h10);
        idle(3);
        rd_chk(5'h08, 32'h4, "R8 reload next lowest");
        rd_chk(5'h0C, 32'd2, "R6 index 2");
        wr(5'h00, 32'h0010_0204);
        wr(5'h08, 32'h4);
        idle(2);
        rd_chk(5'h08, 32'h0, "R8 emptied");
        rd_chk(5'h0C, 32'h0, "R6 empty index");
        check(irq === 1'b0, "R7 irq low", {31'd0, irq}, 32'd0);

        // R4: masked lower bit skipped
        wr(5'h04, ~32'h8);
        pulse_main(32'hA);
        idle(3);
        rd_chk(5'h08, 32'h8, "R4 mask skip");
        wr(5'h00, 32'hA);
        wr(5'h08, 32'h8);
        wr(5'h04, 32'hFFFF_FFFF);
        idle(2);

        // R9: secondary pending, R10: masked group gives no parent
        pulse_sub(11'h010);
        idle(2);
        rd_chk(5'h10, 32'h10, "R9 sub set");
        rd_chk(5'h00, 32'h0, "R10 masked group");
        @(negedge clk); sub_req = 11'h001;
        idle(1);
        wr(5'h10, 32'h1);
        sub_req = '0;
        rd_chk(5'h10, 32'h11, "R3 sub set wins");
        wr(5'h10, 32'h1);
        rd_chk(5'h10, 32'h10, "R9 sub clear");

        // R10: unmask bit 4 -> line 23
        wr(5'h14, 32'h7EF);
        idle(2);
        rd_chk(5'h00, 32'h0080_0000, "R10 group1 to 23");
        wr(5'h10, 32'h10);
        wr(5'h00, 32'h0080_0000);
        idle(2);
        rd_chk(5'h00, 32'h0, "R10 parent drops");
        // group 3 -> line 31, group 2 -> line 15, group 0 -> line 28
        wr(5'h14, 32'h0);
        pulse_sub(11'h400);
        idle(2);
        rd_chk(5'h00, 32'h8000_0000, "R10 group3 to 31");
        wr(5'h10, 32'h400);
        wr(5'h00, 32'h8000_0000);
        pulse_sub(11'h081);
        idle(2);
        rd_chk(5'h00, 32'h1000_8000, "R10 groups 0 and 2");
        wr(5'h10, 32'h081);
        wr(5'h00, 32'h1000_8000);
        wr(5'h14, 32'h7FF);
        idle(2);
        rd_chk(5'h00, 32'h0, "R10 cleanup");

        // R11: index write and unmapped offsets ignored
        wr(5'h0C, 32'h5);
        rd_chk(5'h0C, 32'h0, "R11 index write ignored");
        wr(5'h18, 32'h0);
        rd_chk(5'h04, 32'hFFFF_FFFF, "R11 unmapped write ignored");
        rd_chk(5'h1C, 32'h0, "R11 unmapped read");
        wr(5'h05, 32'h0);
        rd_chk(5'h04, 32'hFFFF_FFFF, "R11 unaligned write ignored");
        idle(3);
        check(reg_rdata === 32'hFFFF_FFFF, "R11 rdata held", reg_rdata, 32'hFFFF_FFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule